// File: doc/BRIEF.md
# H-Bridge PWM Current Chopper Controller

This block is the digital control core for one full-bridge channel of a brushed DC motor driver. It takes a direction input, an enable input and a decay-select input. It also takes three flags from analog circuits: a current-trip comparator output, a near-zero-current detector output and a combined fault flag for over-temperature or supply undervoltage. From these it produces the four gate enables of the bridge, one high-side and one low-side enable for each of the two legs.

With enable high, the block drives the diagonal that matches the direction input. It regulates the winding current with a fixed off-time chopper. A trip from the comparator sets an internal PWM latch, and the bridge then decays for a fixed number of clock cycles. The decay is slow (both low-side switches on) or fast (opposite diagonal on), chosen by the decay-select input. Trips are ignored for a blanking window that follows each high-side turn-on. With enable low, the bridge brakes through both low sides, or it drives the reversed diagonal for fast decay. During fast decay, a near-zero-current indication switches the whole bridge off so that the current never reverses. Every switch turn-on in a leg waits for a dead-time gap in which both switches of that leg are off. All timing windows are parameters counted in system clock cycles.

Top module: `hb_chopper_ctl`

## Requirements
- R1: With fault_i low, en_i high and no off-time running, dir_i=1 drives leg A high and leg B low (a_hi_o=1, b_lo_o=1, the others 0). dir_i=0 drives leg A low and leg B high (a_lo_o=1, b_hi_o=1).
- R2: With en_i low and slow_i high (brake), a_lo_o and b_lo_o are both 1 and both high-side enables are 0. Changes of dir_i have no effect on the outputs in this state.
- R3: With en_i low, slow_i low and zero_i not seen, the reversed diagonal is driven. dir_i=1 gives a_lo_o=1 and b_hi_o=1. dir_i=0 gives a_hi_o=1 and b_lo_o=1.
- R4: The high-side and low-side enables of a leg are never 1 together. Any enable of a leg turns on only after that leg has had both enables at 0 for DEAD_CYC consecutive cycles. A dir_i change while driving leaves each leg fully off for exactly DEAD_CYC cycles.
- R5: trip_i is ignored during the BLANK_CYC cycles that start with the first cycle in which a high-side enable is 1.
- R6: An accepted trip (sampled high with en_i=1, fault_i=0 and the blanking over) turns the high-side enable off two cycles later. The off-time lasts OFF_CYC cycles, so the high-side enable stays 0 for OFF_CYC+DEAD_CYC cycles.
- R7: During the off-time with slow_i=1, both low-side enables are 1.
- R8: During the off-time with slow_i=0, the reversed diagonal is driven (with dir_i=1: a_lo_o=1, b_hi_o=1).
- R9: In any fast-decay state (R3 or R8), zero_i high turns all four enables off in the next cycle. They stay off even after zero_i falls, until the fast-decay state ends.
- R10: fault_i high turns all four enables off in the next cycle. When fault_i clears, normal drive resumes after the dead-time gap.
- R11: When the off-time expires, the drive diagonal for the present direction is restored. This starts a new blanking window, so a trip held high gives another drive span of BLANK_CYC+2 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Bridge enable; low selects brake or reverse fast decay |
| dir_i | input | 1 | Direction: 1 forward (A high, B low), 0 reverse |
| slow_i | input | 1 | Decay select: 1 slow decay, 0 fast decay |
| trip_i | input | 1 | Current comparator flag (sense above a third of reference) |
| zero_i | input | 1 | Near-zero current detect flag |
| fault_i | input | 1 | Thermal or undervoltage fault, active high |
| a_hi_o | output | 1 | Leg A high-side gate enable |
| a_lo_o | output | 1 | Leg A low-side gate enable |
| b_hi_o | output | 1 | Leg B high-side gate enable |
| b_lo_o | output | 1 | Leg B low-side gate enable |

## Verification
Random static combinations of enable, direction, decay select and fault, held with no trip, show whether the decode table separates drive, brake, reversed fast decay and shutdown. A trip held high from power-up measures the drive span and the decay gap. This tells blanking length, latch latency, off-time and dead time apart, and a second span shows the restart of blanking. A trip pulse kept inside the blanking window, direction flips under drive and under brake, and zero-current pulses in both fast-decay flavours separate ignored stimulus from real state changes, and they show the sticky high-impedance cut-off.

// File: rtl/hb_pkg.sv
package hb_pkg;

    typedef enum logic [1:0] {
        LEG_OFF  = 2'd0,
        LEG_HIGH = 2'd1,
        LEG_LOW  = 2'd2
    } leg_e;

    typedef struct packed {
        leg_e a;
        leg_e b;
    } bridge_t;

    typedef struct packed {
        logic en;
        logic dir;
        logic slow;
        logic fault;
    } ctl_t;

    localparam bridge_t BRIDGE_OFF   = '{a: LEG_OFF, b: LEG_OFF};
    localparam bridge_t BRIDGE_BRAKE = '{a: LEG_LOW, b: LEG_LOW};

    // diagonal that pushes current in the direction given
    function automatic bridge_t diag_for(input logic fwd);
        bridge_t d;
        if (fwd) begin
            d.a = LEG_HIGH;
            d.b = LEG_LOW;
        end else begin
            d.a = LEG_LOW;
            d.b = LEG_HIGH;
        end
        return d;
    endfunction

    function automatic logic leg_hi(input leg_e s);
        return s == LEG_HIGH;
    endfunction

    function automatic logic leg_lo(input leg_e s);
        return s == LEG_LOW;
    endfunction

endpackage

// File: rtl/hb_leg.sv
module hb_leg
    import hb_pkg::*;
#(
    parameter int DEAD_CYC = 25
) (
    input  logic clk_i,
    input  logic rst_i,
    input  leg_e req_i,
    output logic hi_o,
    output logic lo_o
);
    localparam int GW = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
    localparam logic [GW-1:0] GAP_LAST = GW'(DEAD_CYC - 1);
    localparam int CW = $clog2(DEAD_CYC + 1);

    leg_e          cur_q;
    logic [GW-1:0] gap_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cur_q <= LEG_OFF;
            gap_q <= '0;
        end else if (cur_q != LEG_OFF) begin
            if (req_i != cur_q) begin
                cur_q <= LEG_OFF;
                gap_q <= '0;
            end
        end else begin
            if (req_i != LEG_OFF && gap_q == GAP_LAST) begin
                cur_q <= req_i;
            end
            if (gap_q != GAP_LAST) begin
                gap_q <= gap_q + GW'(1);
            end
        end
    end

    assign hi_o = leg_hi(cur_q);
    assign lo_o = leg_lo(cur_q);

    // independent count of fully-off cycles seen at the leg outputs
    logic [CW-1:0] idle_q;
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            idle_q <= '0;
        end else if (!hi_o && !lo_o) begin
            if (idle_q != CW'(DEAD_CYC)) idle_q <= idle_q + CW'(1);
        end else begin
            idle_q <= '0;
        end
    end

    AST_DEAD_GAP: assert property (@(posedge clk_i) disable iff (rst_i)
        ($rose(hi_o) || $rose(lo_o)) |-> (idle_q == CW'(DEAD_CYC))); // R4

    AST_NO_DIRECT_SWAP: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(lo_o) |-> !hi_o); // R4

endmodule

// File: rtl/hb_regulator.sv
module hb_regulator #(
    parameter int BLANK_CYC = 50,
    parameter int OFF_CYC   = 1000
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_i,
    input  logic fault_i,
    input  logic trip_i,
    input  logic src_on_i,
    output logic chop_o
);
    localparam int BW = $clog2(BLANK_CYC + 1);
    localparam int OW = $clog2(OFF_CYC + 1);

    logic          src_q;
    logic [BW-1:0] blank_q;
    logic [OW-1:0] off_q;
    logic          chop_q;
    logic          src_rise;
    logic          blanking;
    logic          accept;

    assign src_rise = src_on_i && !src_q;
    assign blanking = src_rise || (blank_q != '0);
    assign accept   = en_i && !fault_i && !chop_q && src_on_i && !blanking && trip_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            src_q   <= 1'b0;
            blank_q <= '0;
        end else begin
            src_q <= src_on_i;
            if (src_rise) begin
                blank_q <= BW'(BLANK_CYC - 1);
            end else if (blank_q != '0) begin
                blank_q <= blank_q - BW'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            chop_q <= 1'b0;
            off_q  <= '0;
        end else if (fault_i || !en_i) begin
            chop_q <= 1'b0;
            off_q  <= '0;
        end else if (chop_q) begin
            if (off_q == '0) begin
                chop_q <= 1'b0;
            end else begin
                off_q <= off_q - OW'(1);
            end
        end else if (accept) begin
            chop_q <= 1'b1;
            off_q  <= OW'(OFF_CYC - 1);
        end
    end

    assign chop_o = chop_q;

    // separate run-length count of the latch for the off-time check
    logic [OW-1:0] run_q;
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            run_q <= '0;
        end else if (chop_q) begin
            if (run_q != OW'(OFF_CYC)) run_q <= run_q + OW'(1);
        end else begin
            run_q <= '0;
        end
    end

    AST_OFF_TIME: assert property (@(posedge clk_i) disable iff (rst_i)
        ($fell(chop_q) && $past(en_i && !fault_i)) |-> (run_q == OW'(OFF_CYC))); // R6

    AST_TRIP_CAUSE: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(chop_q) |-> $past(trip_i && src_on_i)); // R6

endmodule

// File: rtl/hb_mode_select.sv
module hb_mode_select
    import hb_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_i,
    input  ctl_t    ctl_i,
    input  logic    chop_i,
    input  logic    zero_i,
    output bridge_t target_o
);
    logic fast_dec;
    logic zero_q;

    assign fast_dec = !ctl_i.fault && !ctl_i.slow && (!ctl_i.en || chop_i);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            zero_q <= 1'b0;
        end else begin
            zero_q <= fast_dec && (zero_q || zero_i);
        end
    end

    always_comb begin
        if (ctl_i.fault) begin
            target_o = BRIDGE_OFF;
        end else if (ctl_i.en && !chop_i) begin
            target_o = diag_for(ctl_i.dir);
        end else if (ctl_i.slow) begin
            target_o = BRIDGE_BRAKE;
        end else if (zero_q || zero_i) begin
            target_o = BRIDGE_OFF;
        end else begin
            target_o = diag_for(!ctl_i.dir);
        end
    end

endmodule

// File: rtl/hb_chopper_ctl.sv
module hb_chopper_ctl
    import hb_pkg::*;
#(
    parameter int DEAD_CYC  = 25,
    parameter int BLANK_CYC = 50,
    parameter int OFF_CYC   = 1000
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_i,
    input  logic dir_i,
    input  logic slow_i,
    input  logic trip_i,
    input  logic zero_i,
    input  logic fault_i,
    output logic a_hi_o,
    output logic a_lo_o,
    output logic b_hi_o,
    output logic b_lo_o
);
    localparam int NLEG = 2;

    ctl_t    ctl;
    bridge_t target;
    logic    chop;
    logic    src_on;
    leg_e    leg_req [NLEG];
    logic    leg_hi_w [NLEG];
    logic    leg_lo_w [NLEG];

    assign ctl = '{en: en_i, dir: dir_i, slow: slow_i, fault: fault_i};

    hb_mode_select u_mode (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .ctl_i    (ctl),
        .chop_i   (chop),
        .zero_i   (zero_i),
        .target_o (target)
    );

    assign leg_req[0] = target.a;
    assign leg_req[1] = target.b;

    for (genvar g = 0; g < NLEG; g++) begin : g_leg
        hb_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
            .clk_i (clk_i),
            .rst_i (rst_i),
            .req_i (leg_req[g]),
            .hi_o  (leg_hi_w[g]),
            .lo_o  (leg_lo_w[g])
        );
    end

    assign src_on = leg_hi_w[0] || leg_hi_w[1];

    hb_regulator #(.BLANK_CYC(BLANK_CYC), .OFF_CYC(OFF_CYC)) u_reg (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .en_i     (en_i),
        .fault_i  (fault_i),
        .trip_i   (trip_i),
        .src_on_i (src_on),
        .chop_o   (chop)
    );

    assign a_hi_o = leg_hi_w[0];
    assign a_lo_o = leg_lo_w[0];
    assign b_hi_o = leg_hi_w[1];
    assign b_lo_o = leg_lo_w[1];

    AST_FAULT_OFF: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(fault_i) |-> !(a_hi_o || a_lo_o || b_hi_o || b_lo_o)); // R10

    AST_ZERO_CUT: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(zero_i && !en_i && !slow_i && !fault_i)
        |-> !(a_hi_o || a_lo_o || b_hi_o || b_lo_o)); // R9

    AST_BRAKE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(!en_i && slow_i && !fault_i) && $past(a_lo_o && b_lo_o))
        |-> (a_lo_o && b_lo_o && !a_hi_o && !b_hi_o)); // R2

endmodule

// File: tb/hb_chopper_ctl_tb_top.sv
module hb_chopper_ctl_tb_top;
    localparam int DEAD  = 3;
    localparam int BLANK = 5;
    localparam int OFFT  = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0, dir = 1'b0, slow = 1'b0, trip = 1'b0, zero = 1'b0, fault = 1'b0;
    logic a_hi, a_lo, b_hi, b_lo;
    int   checks = 0;
    int   fails  = 0;

    always #10 clk = ~clk;

    hb_chopper_ctl #(.DEAD_CYC(DEAD), .BLANK_CYC(BLANK), .OFF_CYC(OFFT)) dut_i (
        .clk_i (clk), .rst_i (rst), .en_i (en), .dir_i (dir), .slow_i (slow),
        .trip_i (trip), .zero_i (zero), .fault_i (fault),
        .a_hi_o (a_hi), .a_lo_o (a_lo), .b_hi_o (b_hi), .b_lo_o (b_lo)
    );

    function automatic logic [3:0] gates();
        return {a_hi, a_lo, b_hi, b_lo};
    endfunction

    // expected settled outputs {a_hi,a_lo,b_hi,b_lo} with no trip and no zero flag
    function automatic logic [3:0] exp_static(logic e, logic d, logic s, logic f);
        if (f) return 4'b0000;
        if (e) return d ? 4'b1001 : 4'b0110;
        if (s) return 4'b0101;
        return d ? 4'b0110 : 4'b1001;
    endfunction

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(logic ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(3);
        rst = 1'b0;
    endtask

    task automatic wait_hi_a(output int waited);
        waited = 0;
        while (!a_hi && waited < 200) begin
            step();
            waited++;
        end
    endtask

    task automatic span_hi_a(output int n);
        n = 0;
        while (a_hi && n < 200) begin
            step();
            n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int w, n, offs;
        logic saw;
        void'($urandom(32'h1A2B3C4D));
        step(2);
        chk(gates() == 4'b0000, "R10 reset state", gates(), 0);
        do_reset();

        // random static patterns against the decode table
        for (int i = 0; i < 80; i++) begin
            logic [31:0] r = $urandom;
            en = r[0]; dir = r[1]; slow = r[2]; fault = (r[5:3] == 3'd0);
            step(DEAD + 4);
            chk(gates() == exp_static(en, dir, slow, fault),
                en ? "R1 drive decode" : (fault ? "R10 fault off" : (slow ? "R2 brake" : "R3 reverse decay")),
                gates(), exp_static(en, dir, slow, fault));
            chk(!(a_hi && a_lo) && !(b_hi && b_lo), "R4 no shoot-through", gates(), 0);
        end
        fault = 1'b0;

        // R4: direction flip under drive
        do_reset();
        en = 1; dir = 1; slow = 1;
        step(DEAD + 4);
        chk(gates() == 4'b1001, "R1 forward", gates(), 4'b1001);
        dir = 0;
        step();
        offs = 0;
        while (!a_lo && offs < 50) begin
            if (!a_hi) offs++;
            step();
        end
        chk(offs == DEAD, "R4 dead gap on flip", offs, DEAD);
        step(2);
        chk(gates() == 4'b0110, "R1 reverse", gates(), 4'b0110);

        // R2: brake ignores direction
        en = 0; slow = 1;
        step(DEAD + 3);
        saw = 1'b1;
        for (int i = 0; i < 10; i++) begin
            dir = ~dir;
            step();
            if (gates() != 4'b0101) saw = 1'b0;
        end
        chk(saw, "R2 brake holds through dir toggles", gates(), 4'b0101);

        // R5/R6/R7/R11: trip held high from the start, slow decay
        do_reset();
        en = 1; dir = 1; slow = 1; trip = 1;
        wait_hi_a(w);
        span_hi_a(n);
        chk(n == BLANK + 2, "R5 R6 first drive span", n, BLANK + 2);
        n = 0; saw = 1'b0;
        while (!a_hi && n < 200) begin
            if (a_lo && b_lo) saw = 1'b1;
            step();
            n++;
        end
        chk(n == OFFT + DEAD, "R6 off gap", n, OFFT + DEAD);
        chk(saw, "R7 slow decay both low", saw, 1);
        span_hi_a(n);
        chk(n == BLANK + 2, "R11 blanking restarts", n, BLANK + 2);
        trip = 0;

        // R5: trip pulse confined to the blanking window
        do_reset();
        en = 1; dir = 1; slow = 1; trip = 0;
        wait_hi_a(w);
        trip = 1;
        step(BLANK);
        trip = 0;
        step(OFFT + 10);
        chk(gates() == 4'b1001, "R5 trip during blank ignored", gates(), 4'b1001);

        // R8/R9: fast decay chop with zero-current cut
        do_reset();
        en = 1; dir = 1; slow = 0; trip = 1;
        wait_hi_a(w);
        span_hi_a(n);
        trip = 0;
        step(DEAD);
        chk(gates() == 4'b0110, "R8 fast decay diagonal", gates(), 4'b0110);
        zero = 1;
        step();
        chk(gates() == 4'b0000, "R9 zero cut", gates(), 0);
        zero = 0;
        step();
        chk(gates() == 4'b0000, "R9 cut is sticky", gates(), 0);
        wait_hi_a(w);
        chk(a_hi, "R11 drive restored after off-time", a_hi, 1);

        // R3/R9: enable-low fast decay with zero flag
        en = 0; slow = 0; dir = 1;
        step(DEAD + 4);
        chk(gates() == 4'b0110, "R3 reverse decay dir1", gates(), 4'b0110);
        zero = 1;
        step();
        zero = 0;
        step(4);
        chk(gates() == 4'b0000, "R9 zero cut enable low", gates(), 0);
        slow = 1;
        step(DEAD + 3);
        chk(gates() == 4'b0101, "R2 brake after cut", gates(), 4'b0101);

        // R10: fault during drive and recovery
        en = 1; dir = 1; slow = 1;
        step(DEAD + 4);
        fault = 1;
        step();
        chk(gates() == 4'b0000, "R10 fault cuts next cycle", gates(), 0);
        fault = 0;
        step(DEAD + 3);
        chk(gates() == 4'b1001, "R10 resume after fault", gates(), 4'b1001);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule